// File: doc/BRIEF.md
# Multi-cycle arithmetic and compare unit

This block is the 32-bit execution unit of a small microcoded processor. A controller presents an A operand, a B operand and three codes: one picks the right-hand operand, one picks an arithmetic, logic or shift operation, and one picks a comparison. When the unit starts, it produces a 32-bit result and a single compare-true bit. It raises `valid` when both are ready. The controller stalls on `valid` before it uses either one. A compare-true bit usually feeds a conditional branch in the microcode.

The right-hand operand is either B or one of the small constants 4, 2 and 1. These constants let the microcode step a program counter without loading an operand. Arithmetic and logic operations finish one cycle after start. Shifts move one bit position per cycle, so their completion time depends on the shift amount. The `en` input works as a level-sensitive start with a hold. While `en` stays high the finished result is held. Lowering `en` releases the unit, and a new operation starts the next time `en` is high.

Top module: `mc_alu`

## Requirements
- R1: `rhs_sel` picks the right-hand operand: 0 gives `opnd_b`, 1 gives the constant 4, 2 gives the constant 2, and 3 gives the constant 1.
- R2: `op` codes 0 to 6 give, in order: A+rhs, A-rhs, signed A<rhs, unsigned A<rhs, AND, OR and XOR. Both less-than results are zero-extended, with 0 or 1 in bit 0.
- R3: `op` codes 10 to 15 give a result of zero.
- R4: The unit is idle after reset or after any cycle in which `en` was sampled low. When an idle unit samples `en` high at a rising edge, that edge starts an operation. For `op` codes other than 7, 8 and 9, `valid` is high in the cycle that follows that edge.
- R5: Once `valid` is high, it stays high while `en` stays high. During that time `result` and `cmp_true` keep their values, and changes to the operands or codes have no effect. `valid` goes low in the cycle after `en` is sampled low.
- R6: `op` code 7 is a logical left shift, 8 a logical right shift and 9 an arithmetic right shift. The shift amount n is the low 5 bits of the right-hand operand. `valid` rises n+1 cycles after the start edge and stays low before that.
- R7: `cmp_cmp` is latched at start and `cmp_true` reports it. `cmp_op` codes 0 to 5 are equal, not equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal, each comparing A with the right-hand operand. Codes 6 and 7 give 0.
- R8: If `en` is sampled low while a shift is still running, the shift is abandoned and `valid` stays low. The next start then behaves normally.
- R9: After reset, `valid`, `result` and `cmp_true` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Start and hold request |
| op | input | 4 | Operation code |
| cmp_op | input | 3 | Compare code |
| rhs_sel | input | 2 | Right-hand operand select |
| opnd_a | input | 32 | A operand |
| opnd_b | input | 32 | B operand |
| result | output | 32 | Operation result, meaningful while valid |
| cmp_true | output | 1 | Compare outcome, meaningful while valid |
| valid | output | 1 | Result and compare outcome ready |

## Verification
Every operation is timed from the rising edge that first samples `en` high. Non-shift results are due one cycle after that edge, and a shift by n is due n+1 cycles after it. The bench drives inputs on falling edges and counts falling edges until `valid` appears. It compares that count with the expected latency computed from the vector, then reads `result` and `cmp_true` at that same falling edge. Release is checked one falling edge after `en` is lowered. The hold and abort tests watch `valid` at every falling edge across the window in question.

// File: rtl/mc_alu_pkg.sv
package mc_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0, OP_SUB  = 4'd1, OP_SLT = 4'd2, OP_SLTU = 4'd3,
    OP_AND  = 4'd4, OP_OR   = 4'd5, OP_XOR = 4'd6,
    OP_SLL  = 4'd7, OP_SRL  = 4'd8, OP_SRA = 4'd9
  } alu_op_e;

  typedef enum logic [2:0] {
    CMP_EQ = 3'd0, CMP_NE = 3'd1, CMP_LT = 3'd2,
    CMP_GE = 3'd3, CMP_LTU = 3'd4, CMP_GEU = 3'd5
  } cmp_op_e;

  typedef enum logic [1:0] {
    SEL_B = 2'd0, SEL_K4 = 2'd1, SEL_K2 = 2'd2, SEL_K1 = 2'd3
  } rhs_sel_e;

  typedef enum logic [1:0] {SH_LEFT, SH_RLOG, SH_RARI} sh_kind_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} alu_state_e;

  function automatic logic is_shift(input logic [3:0] code);
    return (code == OP_SLL) || (code == OP_SRL) || (code == OP_SRA);
  endfunction
endpackage

// File: rtl/mc_alu_rhs_mux.sv
module mc_alu_rhs_mux
  import mc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [1:0]   sel,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] rhs
);
  always_comb begin
    case (rhs_sel_e'(sel))
      SEL_B:   rhs = b_in;
      SEL_K4:  rhs = W'(4);
      SEL_K2:  rhs = W'(2);
      default: rhs = W'(1);
    endcase
  end
endmodule

// File: rtl/mc_alu_calc.sv
module mc_alu_calc
  import mc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] rhs,
  input  logic [3:0]   op,
  input  logic [2:0]   cmp,
  output logic [W-1:0] value,
  output logic         cmp_true
);
  logic lt_s, lt_u, eq;

  assign lt_s = $signed(a) < $signed(rhs);
  assign lt_u = a < rhs;
  assign eq   = (a == rhs);

  always_comb begin
    case (op)
      OP_ADD:  value = a + rhs;
      OP_SUB:  value = a - rhs;
      OP_SLT:  value = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: value = {{(W-1){1'b0}}, lt_u};
      OP_AND:  value = a & rhs;
      OP_OR:   value = a | rhs;
      OP_XOR:  value = a ^ rhs;
      default: value = '0;
    endcase
  end

  always_comb begin
    case (cmp)
      CMP_EQ:  cmp_true = eq;
      CMP_NE:  cmp_true = !eq;
      CMP_LT:  cmp_true = lt_s;
      CMP_GE:  cmp_true = !lt_s;
      CMP_LTU: cmp_true = lt_u;
      CMP_GEU: cmp_true = !lt_u;
      default: cmp_true = 1'b0;
    endcase
  end
endmodule

// File: rtl/mc_alu_shift.sv
module mc_alu_shift
  import mc_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clear,
  input  logic [1:0]    kind_in,
  input  logic [W-1:0]  operand,
  input  logic [AW-1:0] amount,
  output logic [W-1:0]  value,
  output logic          last
);
  logic [W-1:0]  acc;
  logic [AW-1:0] cnt;
  sh_kind_e      kind;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      cnt  <= '0;
      kind <= SH_LEFT;
    end else if (load) begin
      acc  <= operand;
      cnt  <= amount;
      kind <= sh_kind_e'(kind_in);
    end else if (clear) begin
      cnt <= '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
      case (kind)
        SH_LEFT: acc <= {acc[W-2:0], 1'b0};
        SH_RLOG: acc <= {1'b0, acc[W-1:1]};
        default: acc <= {acc[W-1], acc[W-1:1]};
      endcase
    end
  end

  assign value = acc;
  assign last  = (cnt == AW'(1));
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [3:0]   op,
  input  logic [2:0]   cmp_op,
  input  logic [1:0]   rhs_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  output logic [W-1:0] result,
  output logic         cmp_true,
  output logic         valid
);
  localparam int AW = $clog2(W);

  logic [W-1:0]  rhs, calc_val, sh_val;
  logic          calc_cmp, sh_last, shift_op, start;
  logic [AW-1:0] amt;
  logic [1:0]    kind;
  alu_state_e    st;
  logic [W-1:0]  res_q;
  logic          cmp_q, shift_q;

  mc_alu_rhs_mux #(.W(W)) u_rhs (
    .sel(rhs_sel), .b_in(opnd_b), .rhs(rhs)
  );

  mc_alu_calc #(.W(W)) u_calc (
    .a(opnd_a), .rhs(rhs), .op(op), .cmp(cmp_op),
    .value(calc_val), .cmp_true(calc_cmp)
  );

  assign amt      = rhs[AW-1:0];
  assign shift_op = is_shift(op);
  assign start    = (st == ST_IDLE) && en;

  always_comb begin
    case (op)
      OP_SLL:  kind = SH_LEFT;
      OP_SRL:  kind = SH_RLOG;
      default: kind = SH_RARI;
    endcase
  end

  mc_alu_shift #(.W(W), .AW(AW)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(start && shift_op),
    .clear((st == ST_RUN) && !en),
    .kind_in(kind), .operand(opnd_a), .amount(amt),
    .value(sh_val), .last(sh_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      res_q   <= '0;
      cmp_q   <= 1'b0;
      shift_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (en) begin
          res_q   <= calc_val;
          cmp_q   <= calc_cmp;
          shift_q <= shift_op;
          st      <= (shift_op && amt != '0) ? ST_RUN : ST_DONE;
        end
        ST_RUN: begin
          if (!en)          st <= ST_IDLE;
          else if (sh_last) st <= ST_DONE;
        end
        default: if (!en) st <= ST_IDLE;
      endcase
    end
  end

  assign valid    = (st == ST_DONE);
  assign result   = shift_q ? sh_val : res_q;
  assign cmp_true = cmp_q;
endmodule

// File: rtl/mc_alu_chk.sv
module mc_alu_chk #(
  parameter int W = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [3:0]           op,
  input logic [1:0]           rhs_sel,
  input logic [$clog2(W)-1:0] amt_b,
  input logic [W-1:0]         result,
  input logic                 cmp_true,
  input logic                 valid
);
  logic sh;
  assign sh = (op == 4'd7) || (op == 4'd8) || (op == 4'd9);

  AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(en)); // R5
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !en) |=> !valid); // R5
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && en) |=> (valid && $stable(result) && $stable(cmp_true))); // R5
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && !sh) |=> valid); // R4
  AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && op >= 4'd10) |=> (result == '0)); // R3
  AST_SHIFT_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(en) && sh && (rhs_sel != 2'd0 || amt_b != '0)) |=> !valid); // R6
endmodule

bind mc_alu mc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .op(op), .rhs_sel(rhs_sel),
  .amt_b(opnd_b[AW-1:0]), .result(result), .cmp_true(cmp_true), .valid(valid)
);

// File: tb/mc_alu_tb.sv
`timescale 1ns/1ps
module mc_alu_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [3:0]  op = '0;
  logic [2:0]  cmp_op = '0;
  logic [1:0]  rhs_sel = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] result;
  logic        cmp_true, valid;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mc_alu u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .cmp_op(cmp_op),
    .rhs_sel(rhs_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .cmp_true(cmp_true), .valid(valid)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sel;
    logic [2:0]  cmp;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        ct;
    logic [5:0]  lat;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 2'd0, 3'd0, 32'd5,        32'd7,        32'd12,       1'b0, 6'd1},  // R2 add
    '{4'd0, 2'd1, 3'd1, 32'd10,       32'd0,        32'd14,       1'b1, 6'd1},  // R1 const 4
    '{4'd1, 2'd2, 3'd2, 32'd10,       32'd0,        32'd8,        1'b0, 6'd1},  // R1 const 2
    '{4'd0, 2'd3, 3'd4, 32'hFFFFFFFF, 32'd0,        32'd0,        1'b0, 6'd1},  // R1 const 1
    '{4'd1, 2'd0, 3'd2, 32'd3,        32'd5,        32'hFFFFFFFE, 1'b1, 6'd1},
    '{4'd2, 2'd0, 3'd4, 32'hFFFFFFFF, 32'd1,        32'd1,        1'b0, 6'd1},
    '{4'd3, 2'd0, 3'd5, 32'hFFFFFFFF, 32'd1,        32'd0,        1'b1, 6'd1},
    '{4'd4, 2'd0, 3'd3, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 6'd1},
    '{4'd5, 2'd0, 3'd6, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 6'd1},  // R7 code 6
    '{4'd6, 2'd0, 3'd7, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0FF00FF0, 1'b0, 6'd1},  // R7 code 7
    '{4'd7, 2'd0, 3'd0, 32'd1,        32'h23,       32'd8,        1'b0, 6'd4},  // R6 low 5 bits
    '{4'd8, 2'd0, 3'd5, 32'h80000000, 32'd4,        32'h08000000, 1'b1, 6'd5},
    '{4'd9, 2'd0, 3'd2, 32'h80000000, 32'd4,        32'hF8000000, 1'b1, 6'd5},
    '{4'd7, 2'd0, 3'd0, 32'h1234,     32'd0,        32'h1234,     1'b0, 6'd1},  // R6 zero amount
    '{4'd9, 2'd3, 3'd3, 32'hFFFFFFF0, 32'd0,        32'hFFFFFFF8, 1'b0, 6'd2},
    '{4'd8, 2'd0, 3'd4, 32'h80000000, 32'h1F,       32'd1,        1'b0, 6'd32}, // R6 max amount
    '{4'd10,2'd0, 3'd0, 32'd5,        32'd5,        32'd0,        1'b1, 6'd1},  // R3
    '{4'd15,2'd0, 3'd1, 32'd5,        32'd6,        32'd0,        1'b1, 6'd1},  // R3
    '{4'd2, 2'd0, 3'd0, 32'd5,        32'd5,        32'd0,        1'b1, 6'd1},
    '{4'd1, 2'd0, 3'd3, 32'hFFFFFFFB, 32'd5,        32'hFFFFFFF6, 1'b0, 6'd1}
  };

  function automatic string res_tag(input vec_t v);
    if (v.op >= 4'd10) return "R3";
    if (v.op >= 4'd7) return "R6";
    if (v.sel != 2'd0) return "R1";
    return "R2";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic start_op(input vec_t v);
    @(negedge clk);
    op = v.op; rhs_sel = v.sel; cmp_op = v.cmp;
    opnd_a = v.a; opnd_b = v.b; en = 1'b1;
  endtask

  task automatic wait_valid(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!valid && cyc < 64);
  endtask

  task automatic drop_en();
    en = 1'b0;
    @(negedge clk);
    check("R5", "valid after en low", 32'(valid), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check("R9", "valid", 32'(valid), 32'd0);
    check("R9", "result", result, 32'd0);
    check("R9", "cmp_true", 32'(cmp_true), 32'd0);

    for (int i = 0; i < NV; i++) begin
      int cyc;
      start_op(VECS[i]);
      wait_valid(cyc);
      check(VECS[i].op inside {4'd7, 4'd8, 4'd9} ? "R6" : "R4",
            $sformatf("latency vec %0d", i), 32'(cyc), 32'(VECS[i].lat));
      check(res_tag(VECS[i]), $sformatf("result vec %0d", i), result, VECS[i].res);
      check("R7", $sformatf("cmp vec %0d", i), 32'(cmp_true), 32'(VECS[i].ct));
      drop_en();
    end

    // R5 hold: inputs change while en stays high
    begin
      int cyc;
      start_op('{4'd0, 2'd0, 3'd0, 32'd1, 32'd2, 32'd3, 1'b0, 6'd1});
      wait_valid(cyc);
      opnd_a = 32'd100; op = 4'd1; cmp_op = 3'd1;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check("R5", "held valid", 32'(valid), 32'd1);
        check("R5", "held result", result, 32'd3);
        check("R5", "held cmp", 32'(cmp_true), 32'd0);
      end
      drop_en();
    end

    // R8 abort a long shift
    begin
      int cyc;
      bit seen = 0;
      start_op('{4'd8, 2'd0, 3'd0, 32'hFFFFFFFF, 32'd20, 32'd0, 1'b0, 6'd21});
      repeat (5) @(negedge clk);
      en = 1'b0;
      for (int k = 0; k < 25; k++) begin
        @(negedge clk);
        if (valid) seen = 1;
      end
      check("R8", "valid after abort", 32'(seen), 32'd0);
      start_op('{4'd0, 2'd0, 3'd0, 32'd2, 32'd2, 32'd4, 1'b0, 6'd1});
      wait_valid(cyc);
      check("R8", "restart latency", 32'(cyc), 32'd1);
      check("R8", "restart result", result, 32'd4);
      drop_en();
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule